// File: doc/BRIEF.md
# Single-Shot ADC Conversion Sequencer

This block lets a processor run one conversion at a time on an eight-input analog-to-digital converter through two 32-bit registers. Software writes a control word that picks an input, a sample-clock divider, a reference source and the enables, and sets a start flag in the same write. The sequencer waits for the next converter clock slot and sends one start pulse. It then waits for the converter's completion strobe. It stores the 10-bit sample and sets a sticky completion flag, and this flag can raise a level interrupt.

The start flag stays high for the whole conversion and drops by itself when the sample is stored. Software can therefore poll it and treat a flag that never drops as a hung converter. A soft-reset field in the control word stops a conversion that is in progress and clears the sequencer state until software releases it. The converter itself sits outside the block. It sees a channel select, a start pulse, a reference select and a clock-enable pulse train, and it answers with a 10-bit sample and a one-cycle done strobe.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control word is at byte address 0x00 and the sample word is at 0x04. Any other address reads zero. Control readback places the fields at these bits: channel code in 27:24, interrupt enable in 21, reference select in 19, completion flag in 18, module enable in 17, soft reset in 16, start/busy in 13, divider in 8:1. All other bits read 0.
- R2: A control write with bit 13 = 1, bit 17 = 1 and bit 16 = 0, made while idle, produces exactly one `conv_start` pulse. The pulse falls in a cycle where `conv_clk_en` is high. Bit 13 reads 1 from that write until the conversion is stored.
- R3: A `conv_done` strobe during a conversion stores `conv_data` in bits 9:0 of the sample word, clears bit 13 and sets bit 18.
- R4: Writing 1 to bit 18 clears the completion flag. A control write with bit 18 = 0 leaves the flag as it was.
- R5: `irq` is high exactly while the completion flag (bit 18) and the interrupt enable (bit 21) are both 1.
- R6: While bit 17 = 1 and bit 16 = 0, `conv_clk_en` pulses once every (div+1)*2 clock cycles, where div is bits 8:1.
- R7: A start write with bit 17 = 0 is ignored. No pulse appears on `conv_start`, and bit 13 stays 0.
- R8: While bit 16 = 1, a conversion in progress is aborted. Bits 13 and 18 read 0, and the sample word reads 0.
- R9: The sample word changes only on a `conv_done` strobe during a conversion. A strobe while idle changes neither the sample nor the completion flag.
- R10: `conv_chan` equals the channel code for codes 0 to 7 and is 0 for codes 8 to 15. The control readback keeps the code as written.
- R11: `conv_ref_sel` follows bit 19 of the control word.
- R12: After `rst_n` is released, both words read 0, and `irq` and `conv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| conv_chan | output | 3 | Converter input select |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_clk_en | output | 1 | Converter sample-clock enable pulse |
| conv_ref_sel | output | 1 | Reference source select |
| conv_data | input | 10 | Sample from the converter |
| conv_done | input | 1 | Converter completion strobe |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the out-of-range channel codes. A design that passes the raw code through would select a non-existent input, and the converter model would return a sample that does not match. It also fires a completion strobe while the block is idle, which a design that gates capture wrongly would take as a new sample. It then checks that a write with the flag bit clear does not erase the completion flag, a fault that appears as lost interrupts. Finally it starts a conversion the model never answers and asserts soft reset, where a faulty design would stay busy for good or keep the old sample.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CTL_ADDR  = 8'h00;
  localparam int unsigned RES_ADDR  = 8'h04;
  localparam int unsigned CH_LSB    = 24;
  localparam int unsigned IE_BIT    = 21;
  localparam int unsigned REF_BIT   = 19;
  localparam int unsigned DONE_BIT  = 18;
  localparam int unsigned EN_BIT    = 17;
  localparam int unsigned SRST_BIT  = 16;
  localparam int unsigned GO_BIT    = 13;
  localparam int unsigned DIV_LSB   = 1;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ARM  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_t;
endpackage

// File: rtl/adc_seq_div.sv
module adc_seq_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;

  always_comb begin
    lim = {div, 1'b1};
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (cnt_q >= lim)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic srst,
  input  logic tick,
  input  logic conv_done,
  output logic busy,
  output logic conv_start,
  output logic cap
);
  seq_state_t st_q, st_d;

  always_comb begin
    st_d       = st_q;
    conv_start = 1'b0;
    cap        = 1'b0;
    if (srst) begin
      st_d = SEQ_IDLE;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (start_req) st_d = SEQ_ARM;
        SEQ_ARM: if (tick) begin
          conv_start = 1'b1;
          st_d       = SEQ_WAIT;
        end
        SEQ_WAIT: if (conv_done) begin
          cap  = 1'b1;
          st_d = SEQ_IDLE;
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  assign busy = (st_q != SEQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEQ_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RES_W  = 10,
  parameter int DIV_W  = 8,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              cap,
  input  logic [RES_W-1:0]  cap_data,
  output logic              ie,
  output logic              ref_sel,
  output logic              en,
  output logic              srst,
  output logic [CH_W-1:0]   ch,
  output logic [DIV_W-1:0]  div,
  output logic              done,
  output logic              start_req
);
  logic ie_d, ref_d, en_d, srst_d, done_d;
  logic [CH_W-1:0]  ch_d;
  logic [DIV_W-1:0] div_d;
  logic [RES_W-1:0] res_q, res_d;
  logic ctl_wr;

  assign ctl_wr = bus_we && (bus_addr == ADDR_W'(CTL_ADDR));

  assign start_req = ctl_wr && bus_wdata[GO_BIT] && bus_wdata[EN_BIT] &&
                     !bus_wdata[SRST_BIT] && !busy;

  always_comb begin
    ie_d   = ie;
    ref_d  = ref_sel;
    en_d   = en;
    srst_d = srst;
    ch_d   = ch;
    div_d  = div;
    done_d = done;
    res_d  = res_q;
    if (ctl_wr) begin
      ie_d   = bus_wdata[IE_BIT];
      ref_d  = bus_wdata[REF_BIT];
      en_d   = bus_wdata[EN_BIT];
      srst_d = bus_wdata[SRST_BIT];
      ch_d   = bus_wdata[CH_LSB +: CH_W];
      div_d  = bus_wdata[DIV_LSB +: DIV_W];
      if (bus_wdata[DONE_BIT]) done_d = 1'b0;
    end
    if (cap) begin
      done_d = 1'b1;
      res_d  = cap_data;
    end
    if (srst) begin
      done_d = 1'b0;
      res_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie <= 1'b0; ref_sel <= 1'b0; en <= 1'b0; srst <= 1'b0;
      ch <= '0; div <= '0; done <= 1'b0; res_q <= '0;
    end else begin
      ie <= ie_d; ref_sel <= ref_d; en <= en_d; srst <= srst_d;
      ch <= ch_d; div <= div_d; done <= done_d; res_q <= res_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTL_ADDR)) begin
      bus_rdata[CH_LSB +: CH_W]   = ch;
      bus_rdata[IE_BIT]           = ie;
      bus_rdata[REF_BIT]          = ref_sel;
      bus_rdata[DONE_BIT]         = srst ? 1'b0 : done;
      bus_rdata[EN_BIT]           = en;
      bus_rdata[SRST_BIT]         = srst;
      bus_rdata[GO_BIT]           = srst ? 1'b0 : busy;
      bus_rdata[DIV_LSB +: DIV_W] = div;
    end else if (bus_addr == ADDR_W'(RES_ADDR)) begin
      bus_rdata[RES_W-1:0] = srst ? '0 : res_q;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int RES_W  = 10,
  parameter int DIV_W  = 8,
  parameter int CH_W   = 4,
  parameter int NUM_CH = 8,
  localparam int SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [SEL_W-1:0]  conv_chan,
  output logic              conv_start,
  output logic              conv_clk_en,
  output logic              conv_ref_sel,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              conv_done,
  output logic              irq
);
  logic ie_w, en_w, srst_w, done_w, busy_w, cap_w, start_w;
  logic [CH_W-1:0]  ch_w;
  logic [DIV_W-1:0] div_w;

  adc_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W),
                 .DIV_W(DIV_W), .CH_W(CH_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy_w),
    .cap(cap_w), .cap_data(conv_data), .ie(ie_w), .ref_sel(conv_ref_sel),
    .en(en_w), .srst(srst_w), .ch(ch_w), .div(div_w), .done(done_w),
    .start_req(start_w)
  );

  adc_seq_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(en_w && !srst_w), .div(div_w),
    .tick(conv_clk_en)
  );

  adc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_req(start_w), .srst(srst_w),
    .tick(conv_clk_en), .conv_done(conv_done), .busy(busy_w),
    .conv_start(conv_start), .cap(cap_w)
  );

  generate
    if (CH_W > SEL_W) begin : g_chan_fold
      always_comb
        conv_chan = (ch_w < CH_W'(NUM_CH)) ? ch_w[SEL_W-1:0] : '0;
    end else begin : g_chan_pass
      always_comb conv_chan = SEL_W'(ch_w);
    end
  endgenerate

  assign irq = done_w && ie_w && !srst_w;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_we,
  input logic conv_start,
  input logic conv_clk_en,
  input logic conv_done,
  input logic busy,
  input logic done_q,
  input logic srst_q,
  input logic en_q,
  input logic irq
);
  assert_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_clk_en);
  assert_start_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy);
  assert_done_from_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(conv_done) && $past(busy)));
  assert_irq_drop_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_we));
  assert_no_start_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !conv_start);
  assert_srst_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (!busy && !done_q));
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .conv_start(conv_start),
  .conv_clk_en(conv_clk_en), .conv_done(conv_done), .busy(busy_w),
  .done_q(done_w), .srst_q(srst_w), .en_q(en_w), .irq(irq)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam logic [31:0] IE = 32'h1 << 21, REFS = 32'h1 << 19, DN = 32'h1 << 18,
                          EN = 32'h1 << 17, SR = 32'h1 << 16, GO = 32'h1 << 13;
  localparam int NV = 6;
  // {channel code, divider, expected sample}
  localparam logic [21:0] VEC [NV] = '{
    {4'd0, 8'd0, 10'd13}, {4'd7, 8'd2, 10'd692}, {4'd3, 8'd1, 10'd304},
    {4'd9, 8'd0, 10'd13}, {4'd15, 8'd3, 10'd13}, {4'd5, 8'd0, 10'd498}};

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [2:0] conv_chan, rch;
  logic conv_start, conv_clk_en, conv_ref_sel, irq;
  logic [9:0] resp_data;
  logic resp_done, stray, mute;
  logic [2:0] rcnt;
  int nstart, tests, fails;

  always #10 clk = ~clk;

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_chan(conv_chan),
    .conv_start(conv_start), .conv_clk_en(conv_clk_en),
    .conv_ref_sel(conv_ref_sel), .conv_data(stray ? 10'h3FF : resp_data),
    .conv_done(resp_done | stray), .irq(irq));

  // behavioural converter: answers three cycles after a start
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt <= 0; resp_done <= 0; resp_data <= 0; rch <= 0; nstart <= 0;
    end else begin
      resp_done <= 0;
      if (conv_start) begin
        rcnt <= 3; rch <= conv_chan; nstart <= nstart + 1;
      end else if (rcnt != 0) begin
        rcnt <= rcnt - 1;
        if (rcnt == 1 && !mute) begin
          resp_done <= 1; resp_data <= 10'(rch * 97 + 13);
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h00, v);
      if (!v[13]) break;
    end
  endtask

  task automatic measure(logic [7:0] dv, output int per);
    int c;
    wr(8'h00, EN | (32'(dv) << 1));
    @(negedge clk);
    while (!conv_clk_en) @(negedge clk);
    c = 0;
    @(negedge clk); c++;
    while (!conv_clk_en) begin @(negedge clk); c++; end
    per = c;
  endtask

  initial begin
    #(200000 * 20);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    int s0, per;
    stray = 0; mute = 0; tests = 0; fails = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    rd(8'h00, v); chk("R12 ctl", v, 0);
    rd(8'h04, v); chk("R12 res", v, 0);
    chk("R12 irq", {31'd0, irq}, 0);
    chk("R12 start", {31'd0, conv_start}, 0);

    // R1/R11 field placement and readback
    w = IE | REFS | EN | (32'd5 << 24) | (32'h5A << 1);
    wr(8'h00, w);
    rd(8'h00, v); chk("R1 readback", v, w);
    chk("R11 ref out", {31'd0, conv_ref_sel}, 1);
    rd(8'h08, v); chk("R1 unmapped", v, 0);
    wr(8'h00, EN);
    chk("R11 ref low", {31'd0, conv_ref_sel}, 0);

    // table of conversions
    for (int k = 0; k < NV; k++) begin
      logic [3:0] cc; logic [7:0] dv; logic [9:0] ex;
      {cc, dv, ex} = VEC[k];
      s0 = nstart;
      w = IE | EN | (32'(cc) << 24) | (32'(dv) << 1);
      wr(8'h00, w | GO);
      rd(8'h00, v); chk("R2 busy", 32'(v[13]), 1);
      wait_idle();
      chk("R2 one pulse", nstart - s0, 1);
      chk("R10 chan map", 32'(rch), (cc < 8) ? 32'(cc) : 0);
      rd(8'h04, v); chk("R3 sample", v, 32'(ex));
      rd(8'h00, v); chk("R3 done set", v, w | DN);
      chk("R5 irq high", {31'd0, irq}, 1);
      wr(8'h00, w | DN);
      rd(8'h00, v); chk("R4 w1c", 32'(v[18]), 0);
      chk("R5 irq low", {31'd0, irq}, 0);
    end

    // R4 write with flag bit 0 keeps it; R5 ie=0 keeps irq low
    wr(8'h00, EN | GO | (32'd2 << 24));
    wait_idle();
    wr(8'h00, EN | (32'd2 << 24));
    rd(8'h00, v); chk("R4 keep", 32'(v[18]), 1);
    chk("R5 no ie", {31'd0, irq}, 0);
    wr(8'h00, EN | IE | (32'd2 << 24));
    chk("R5 ie on", {31'd0, irq}, 1);

    // R9 stray strobe while idle
    wr(8'h00, EN | DN);
    @(negedge clk); stray = 1; @(negedge clk); stray = 0;
    rd(8'h04, v); chk("R9 hold", v, 32'd207);
    rd(8'h00, v); chk("R9 no flag", 32'(v[18]), 0);

    // R6 divider period
    measure(8'd4, per); chk("R6 div4", per, 10);
    measure(8'd0, per); chk("R6 div0", per, 2);
    measure(8'd9, per); chk("R6 div9", per, 20);

    // R7 start while disabled
    s0 = nstart;
    wr(8'h00, GO | (32'd1 << 24));
    rd(8'h00, v); chk("R7 no busy", 32'(v[13]), 0);
    repeat (40) @(negedge clk);
    chk("R7 no pulse", nstart - s0, 0);
    rd(8'h04, v); chk("R7 sample kept", v, 32'd207);

    // R8 soft reset aborts a hung conversion
    mute = 1;
    wr(8'h00, EN | GO | (32'd4 << 24));
    repeat (10) @(negedge clk);
    rd(8'h00, v); chk("R8 hung busy", 32'(v[13]), 1);
    wr(8'h00, EN | SR);
    rd(8'h00, v); chk("R8 busy clr", 32'(v[13]), 0);
    rd(8'h04, v); chk("R8 res zero", v, 0);
    mute = 0;
    wr(8'h00, EN);
    rd(8'h00, v); chk("R8 after", v, EN);
    rd(8'h04, v); chk("R8 res stays", v, 0);
    wr(8'h00, EN | GO | (32'd6 << 24));
    wait_idle();
    rd(8'h04, v); chk("R3 after srst", v, 32'd595);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule